// File: doc/BRIEF.md
# Serial Configuration Write Master

This block drives a three-wire configuration port on an external analog device: a generated serial clock, a serial data line and an active-low enable. Register writes arrive from the host side on a valid/ready interface as a 5-bit address and an 8-bit data byte. Each accepted write becomes one serial frame. While more writes are waiting, frames follow one another inside a single low period of the enable. When the host pulses a commit strobe, or when no further write is waiting, the block raises the enable. The device applies the whole batch on that rising edge.

The serial clock comes from the system clock through a half-period counter, so its duty cycle is exactly 50 %. Two rates are available, each set by a parameter. A flag on each request selects the slow rate for that frame, which is needed when the device's measurement registers are accessed. A write to address zero carries only one meaningful bit. The block places that bit in the most significant position and fills the other seven with ones.

Top module: `sercfg_write_master`

## Requirements
- R1: Each frame is sent on `sdo` as a 0 start bit, a 0 write flag, the five address bits MSB first, the eight data bits MSB first and two 1 stop bits.
- R2: For address 0 the data field sent is the request's bit 7 followed by seven ones (request data 0x00 gives 0x7F, 0x80 gives 0xFF).
- R3: `sdo` changes only in the same cycle as a rising edge of `sclk`, and it is stable while `sclk` is low.
- R4: While `en_n` is low, every high phase and every low phase of `sclk` lasts exactly the selected half period: FAST_HALF system cycles, or SLOW_HALF cycles for a slow frame.
- R5: A request with `req_slow` = 1 is sent at the slow rate. A request with `req_slow` = 0 is sent at the fast rate.
- R6: Before each start bit, `sdo` is 1 for at least one full `sclk` period while `en_n` is low.
- R7: `en_n` stays low from before the first frame of a batch until after the last stop bit. A write that is waiting when a frame ends goes out in the same enable window.
- R8: A `commit` pulse while `en_n` is low ends the batch after the frame in progress. A waiting write is held off until the next batch.
- R9: When no write is waiting at the end of a frame, `en_n` rises and the batch ends.
- R10: After a batch, `en_n` stays high for at least two half periods. `sclk` and `sdo` are 1 whenever `en_n` is high.
- R11: A `commit` pulse while the block is idle has no effect: `en_n` and `sclk` stay high and no frame is sent.
- R12: After reset `en_n`, `sclk` and `sdo` are 1 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request taken in this cycle when valid |
| req_addr | input | 5 | Target register address |
| req_data | input | 8 | Register data |
| req_slow | input | 1 | Send this frame at the slow rate |
| commit | input | 1 | Pulse: close the current batch after the frame in progress |
| sclk | output | 1 | Generated serial clock, idles high |
| sdo | output | 1 | Serial data, changes on the rising edge of sclk |
| en_n | output | 1 | Active-low enable; its rising edge applies the batch |

## Verification
The assertions assume that the host holds `req_addr`, `req_data` and `req_slow` steady while `req_valid` waits for `req_ready`. They also assume that `commit` is a single-cycle pulse and that both half-period parameters are at least one, with the slow one no smaller than the fast one. The stimulus drives and releases every input on the falling system-clock edge. It keeps each request steady until the handshake and gives `commit` for exactly one cycle. An attached receiver model decodes the frames at the port and measures each phase length, without looking into the design.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = 18;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } wm_state_e;

    // Bits leave MSB first: the idle pad, then the frame proper.
    typedef struct packed {
        logic              pad;
        logic              start;
        logic              wflag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        stop;
    } wm_frame_t;

    function automatic wm_frame_t build_frame(input logic [ADDR_W-1:0] a,
                                              input logic [DATA_W-1:0] d);
        wm_frame_t f;
        f.pad   = 1'b1;
        f.start = 1'b0;
        f.wflag = 1'b0;
        f.addr  = a;
        f.data  = (a == '0) ? {d[DATA_W-1], {(DATA_W-1){1'b1}}} : d;
        f.stop  = 2'b11;
        return f;
    endfunction

endpackage

// File: rtl/sercfg_halfcnt.sv
module sercfg_halfcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] lim,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = !clear && (cnt == lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // R4: the phase counter never runs past the selected limit
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt < lim);

endmodule

// File: rtl/sercfg_frame_shift.sv
module sercfg_frame_shift
    import sercfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  cur_bit,
    output logic                  last
);
    localparam int RW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] sh;
    logic [RW-1:0]         rem;

    assign cur_bit = sh[FRAME_BITS-1];
    assign last    = (rem == RW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '1;
            rem <= '0;
        end else if (load) begin
            sh  <= word;
            rem <= RW'(FRAME_BITS);
        end else if (shift) begin
            sh  <= {sh[FRAME_BITS-2:0], 1'b1};
            rem <= rem - 1'b1;
        end
    end

    // R1: a shift is only requested while frame bits remain
    a_r1_shift_in_frame: assert property (@(posedge clk) disable iff (rst)
        shift |-> (rem > RW'(1)));

    // R1: a freshly loaded frame begins with its pad bit
    a_r1_load_pad_first: assert property (@(posedge clk) disable iff (rst)
        load |=> cur_bit);

endmodule

// File: rtl/sercfg_write_master.sv
module sercfg_write_master
    import sercfg_pkg::*;
#(
    parameter int FAST_HALF = 50,
    parameter int SLOW_HALF = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_slow,
    input  logic              commit,
    output logic              sclk,
    output logic              sdo,
    output logic              en_n
);
    localparam int CW = $clog2(2 * SLOW_HALF + 1);

    wm_state_e     state;
    logic          slow_q;
    logic          commit_pend;
    logic [CW-1:0] half_lim;
    logic [CW-1:0] lim;
    logic          tick;
    logic          cur_bit;
    logic          last;
    logic          frame_end;
    logic          accept;
    logic          shift;
    wm_frame_t     frame;

    assign half_lim  = slow_q ? CW'(SLOW_HALF) : CW'(FAST_HALF);
    assign lim       = (state == ST_GAP) ? (half_lim << 1) : half_lim;
    assign frame_end = (state == ST_LOW) && tick && last;
    assign req_ready = (state == ST_IDLE) || (frame_end && !(commit || commit_pend));
    assign accept    = req_valid && req_ready;
    assign shift     = (state == ST_LOW) && tick && !last;
    assign frame     = build_frame(req_addr, req_data);

    sercfg_halfcnt #(.CW(CW)) u_halfcnt (
        .clk   (clk),
        .rst   (rst),
        .clear (state == ST_IDLE),
        .lim   (lim),
        .tick  (tick)
    );

    sercfg_frame_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .shift   (shift),
        .word    (frame),
        .cur_bit (cur_bit),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            slow_q      <= 1'b0;
            commit_pend <= 1'b0;
        end else begin
            if (accept) slow_q <= req_slow;

            if (state == ST_IDLE || state == ST_GAP) commit_pend <= 1'b0;
            else if (commit)                         commit_pend <= 1'b1;

            unique case (state)
                ST_IDLE: if (accept) state <= ST_HIGH;
                ST_HIGH: if (tick)   state <= ST_LOW;
                ST_LOW:  if (tick) begin
                    if (!last || accept) state <= ST_HIGH;
                    else                 state <= ST_GAP;
                end
                ST_GAP:  if (tick)   state <= ST_IDLE;
                default:             state <= ST_IDLE;
            endcase
        end
    end

    assign sclk = (state != ST_LOW);
    assign en_n = (state == ST_IDLE) || (state == ST_GAP);
    assign sdo  = en_n ? 1'b1 : cur_bit;

    // R3: data is stable while the serial clock is low
    a_r3_sdo_stable_low: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> $stable(sdo));

    // R3: data only moves together with a rising serial clock edge
    a_r3_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $rose(sclk));

    // R10: lines idle high while the enable is high
    a_r10_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (sclk && sdo));

    // R10: enable stays high for more than one cycle after it rises
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(en_n) |=> en_n);

    // R8: no request is taken while a commit is pending inside a batch
    a_r8_commit_blocks_accept: assert property (@(posedge clk) disable iff (rst)
        (commit && !en_n) |-> !req_ready);

    // R9: a batch closes on the last stop bit
    a_r9_close_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(en_n) |-> $past(sdo));

endmodule

// File: tb/test_sercfg_write_master.sv
module test_sercfg_write_master;

    localparam int FAST = 3;
    localparam int SLOW = 9;
    localparam int NV   = 8;

    typedef struct packed {
        logic [4:0] a;
        logic [7:0] d;
        logic       slow;
        logic       cmt;
        logic       gap;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{5'h03, 8'hA5, 1'b0, 1'b0, 1'b0},
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'h1F, 8'h3C, 1'b0, 1'b1, 1'b0},
        '{5'h00, 8'h80, 1'b0, 1'b0, 1'b0},
        '{5'h10, 8'h01, 1'b1, 1'b0, 1'b0},
        '{5'h05, 8'hFE, 1'b1, 1'b0, 1'b1},
        '{5'h0A, 8'h55, 1'b0, 1'b1, 1'b0},
        '{5'h01, 8'hC3, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       req_slow = 1'b0;
    logic       commit = 1'b0;
    logic       sclk, sdo, en_n;

    always #5 clk = ~clk;

    sercfg_write_master #(.FAST_HALF(FAST), .SLOW_HALF(SLOW)) i_sercfg_write_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_slow(req_slow),
        .commit(commit), .sclk(sclk), .sdo(sdo), .en_n(en_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d, want %0d", req, act, exp);
        end
    endtask

    // receiver model, sampled on the falling system clock edge
    logic        p_sclk = 1'b1, p_en = 1'b1;
    int          run_len = 0, hi_len = 0, lo_len = 0;
    int          en_hi_len = 0;
    bit          in_frame = 1'b0;
    int          nbits = 0, pad_ones = 0;
    logic [15:0] sh = '0;
    int          n_rx = 0, batch = 0, batches_seen = 0;
    int          duty_err = 0, idle_err = 0, gap_err = 0, gap_cnt = 0;
    int          last_half = FAST;
    logic [15:0] rx_bits [NV];
    int          rx_batch [NV];
    int          rx_half [NV];
    int          rx_pad [NV];

    always @(negedge clk) begin
        if (!rst) begin
            if (en_n && !(sclk && sdo)) idle_err++;
            if (sclk != p_sclk || en_n != p_en) begin
                if (p_sclk && !sclk && !p_en) begin
                    hi_len = run_len;
                    if (!in_frame) begin
                        if (sdo == 1'b0) begin
                            in_frame = 1'b1;
                            nbits = 0;
                        end else pad_ones++;
                    end else begin
                        sh = {sh[14:0], sdo};
                        nbits++;
                        if (nbits == 16) begin
                            if (n_rx < NV) begin
                                rx_bits[n_rx]  = sh;
                                rx_batch[n_rx] = batch;
                                rx_half[n_rx]  = lo_len;
                                rx_pad[n_rx]   = pad_ones;
                            end
                            n_rx++;
                            in_frame = 1'b0;
                            pad_ones = 0;
                            last_half = lo_len;
                        end
                    end
                end
                if (!p_sclk && sclk && !p_en) begin
                    lo_len = run_len;
                    if (lo_len != hi_len || (lo_len != FAST && lo_len != SLOW)) duty_err++;
                end
                if (!p_en && en_n) begin
                    batch++;
                    batches_seen++;
                    if (in_frame) duty_err++;
                    en_hi_len = 0;
                end
                if (p_en && !en_n && batches_seen > 0) begin
                    gap_cnt++;
                    if (en_hi_len < 2 * last_half) gap_err++;
                end
                run_len = 1;
            end else run_len++;
            if (en_n) en_hi_len++;
            p_sclk = sclk;
            p_en   = en_n;
        end
    end

    task automatic show_summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            show_summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(en_n == 1'b1, "R12 en_n", int'(en_n), 1);
        chk(sclk == 1'b1, "R12 sclk", int'(sclk), 1);
        chk(sdo == 1'b1, "R12 sdo", int'(sdo), 1);
        chk(req_ready == 1'b1, "R12 req_ready", int'(req_ready), 1);

        // R11: commit while idle does nothing
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        begin
            int low_seen = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (!en_n || !sclk) low_seen++;
            end
            chk(low_seen == 0, "R11 lines stayed idle", low_seen, 0);
            chk(n_rx == 0, "R11 no frame", n_rx, 0);
        end

        // walk the vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].gap) begin
                while (!en_n) @(negedge clk);
                repeat (5) @(negedge clk);
            end
            req_valid = 1'b1;
            req_addr  = VECS[i].a;
            req_data  = VECS[i].d;
            req_slow  = VECS[i].slow;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            if (VECS[i].cmt) begin
                commit = 1'b1;
                @(negedge clk);
                commit = 1'b0;
            end
        end
        while (n_rx < NV || !en_n) @(negedge clk);
        repeat (4 * SLOW) @(negedge clk);

        chk(n_rx == NV, "R1 frame count", n_rx, NV);
        begin
            int eb = 0;
            for (int i = 0; i < NV; i++) begin
                logic [7:0] ed;
                if (i > 0 && (VECS[i-1].cmt || VECS[i].gap)) eb++;
                ed = (VECS[i].a == 5'd0) ? {VECS[i].d[7], 7'h7F} : VECS[i].d;
                chk(rx_bits[i][15] == 1'b0, "R1 write flag", int'(rx_bits[i][15]), 0);
                chk(rx_bits[i][14:10] == VECS[i].a, "R1 address", int'(rx_bits[i][14:10]), int'(VECS[i].a));
                chk(rx_bits[i][1:0] == 2'b11, "R1 stop bits", int'(rx_bits[i][1:0]), 3);
                if (VECS[i].a == 5'd0)
                    chk(rx_bits[i][9:2] == ed, "R2 address zero fill", int'(rx_bits[i][9:2]), int'(ed));
                else
                    chk(rx_bits[i][9:2] == ed, "R1 data", int'(rx_bits[i][9:2]), int'(ed));
                chk(rx_half[i] == (VECS[i].slow ? SLOW : FAST), "R5 rate", rx_half[i],
                    VECS[i].slow ? SLOW : FAST);
                chk(rx_pad[i] >= 1, "R6 idle one before start", rx_pad[i], 1);
                // R7 same window, R8 commit split, R9 empty-queue split
                chk(rx_batch[i] == eb, "R7 R8 R9 batch index", rx_batch[i], eb);
            end
            chk(batches_seen == eb + 1, "R9 batch count", batches_seen, eb + 1);
        end
        chk(duty_err == 0, "R4 phase lengths", duty_err, 0);
        chk(idle_err == 0, "R10 idle lines high", idle_err, 0);
        chk(gap_err == 0, "R10 enable high gap", gap_err, 0);
        chk(gap_cnt == 3, "R10 gaps observed", gap_cnt, 3);

        done = 1'b1;
        show_summary();
        $finish;
    end

endmodule